// File: doc/BRIEF.md
# Three-Stage Cascaded First-Order Noise-Shaping Modulator

This block turns a fine-grained digital code into a short multi-level word whose quantization error is pushed towards high frequencies with third-order shaping. It chains three first-order accumulator loops. Each loop is a wrap-around adder. Its overflow bit is the loop's one-bit decision and its leftover remainder is the quantization error of that loop. The first loop accumulates the input code. The second loop accumulates the remainder left by the first, and the third loop accumulates the remainder left by the second. Each loop is stable whatever its input, so the cascade can never run away, unlike a single loop of high order.

The three one-bit decisions are merged by a digital network. The first stage bit is taken as it is. The second stage bit passes through one first difference and the third stage bit through two. Delay registers line the three terms up in time. After the merge, the errors of stages one and two cancel and only the third-order-differenced error of stage three is left. Input codes are taken only on a valid strobe and held between strobes. The modulator itself advances on every clock and produces a new output word each cycle.

Top module: `mash3_modulator`

## Requirements
- R1: While reset is asserted, and after its release for as long as the held input code is 0, `level_out` reads 0.
- R2: `code_in` is captured on a rising clock edge only when `code_valid` is 1. With `code_valid` at 0, the previously captured code stays in use, and changes on `code_in` have no effect on the output sequence.
- R3: `level_out` is a 4-bit two's complement word that always lies in the range -3 to +4.
- R4: Number the clock edges after reset from t = 1, and let b1(t), b2(t), b3(t) be the overflow bits the three stages produce at edge t, with any b(t <= 0) = 0. The output registered at edge t is b1(t-2) + b2(t-1) - b2(t-2) + b3(t) - 2*b3(t-1) + b3(t-2).
- R5: Each stage is a CODE_W-bit accumulator taken modulo 2^CODE_W, and its overflow is that stage's bit. At edge t, stage 1 adds the held code from edge t-1. Stage 2 adds stage 1's accumulator value from edge t-1, and stage 3 adds stage 2's accumulator value from edge t-1.
- R6: For a code x held constant from the first edge after reset, the sum of the first T outputs differs from floor((T-3)*x / 2^CODE_W) by at most 2.
- R7: The extreme codes 0 and 2^CODE_W - 1 are valid inputs and follow R4 exactly.
- R8: A code captured at edge t leaves the outputs registered at edges t+1 and t+2 unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low; clears all accumulators and delay registers |
| code_valid | input | 1 | Capture strobe for `code_in` |
| code_in | input | CODE_W | Unsigned input code; the long-run mean output is code_in / 2^CODE_W |
| level_out | output | 4 | Signed output level, -3 to +4 |

## Verification
The sharpest coincidence is a new code arriving on the same edge on which an earlier code's second- and third-stage carries are still emerging through the alignment delays. At that moment the capture register, three wrapping accumulators and the six-bit carry history all change together. The bench provokes this by changing the code on every cycle, and also in random bursts with the strobe toggling, including jumps between 0 and the largest code. A behavioural model built from integer arithmetic and carry queues judges every cycle's output word. It also judges the held-code case, where `code_in` moves while the strobe is low and the output must not notice.

// File: rtl/mash3_modulator.sv
module mash3_modulator #(
  parameter int CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              code_valid,
  input  logic [CODE_W-1:0] code_in,
  output logic [3:0]        level_out
);

  localparam int SUM_W = CODE_W + 1;
  localparam int LVL_W = 4;

  logic [CODE_W-1:0] held, acc1, acc2, acc3;
  logic [SUM_W-1:0]  sum1, sum2, sum3;
  logic              ovf1, ovf2, ovf3;
  logic [1:0]        hist1, hist2, hist3;
  logic signed [LVL_W-1:0] merged;
  logic signed [LVL_W-1:0] level_q;

  assign sum1 = {1'b0, acc1} + {1'b0, held};
  assign sum2 = {1'b0, acc2} + {1'b0, acc1};
  assign sum3 = {1'b0, acc3} + {1'b0, acc2};
  assign ovf1 = sum1[CODE_W];
  assign ovf2 = sum2[CODE_W];
  assign ovf3 = sum3[CODE_W];

  always_comb begin
    merged = LVL_W'(hist1[1])
           + LVL_W'(hist2[0]) - LVL_W'(hist2[1])
           + LVL_W'(ovf3) - (LVL_W'(hist3[0]) <<< 1) + LVL_W'(hist3[1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held    <= '0;
      acc1    <= '0;
      acc2    <= '0;
      acc3    <= '0;
      hist1   <= '0;
      hist2   <= '0;
      hist3   <= '0;
      level_q <= '0;
    end else begin
      if (code_valid) held <= code_in;
      acc1    <= sum1[CODE_W-1:0];
      acc2    <= sum2[CODE_W-1:0];
      acc3    <= sum3[CODE_W-1:0];
      hist1   <= {hist1[0], ovf1};
      hist2   <= {hist2[0], ovf2};
      hist3   <= {hist3[0], ovf3};
      level_q <= merged;
    end
  end

  assign level_out = level_q;

  assert_level_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($signed(level_out) >= -3) && ($signed(level_out) <= 4));

  assert_hold_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !code_valid |=> held == $past(held));

  assert_stage1_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ({hist1[0], acc1} == {1'b0, $past(acc1)} + {1'b0, $past(held)}));

  assert_stage3_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ({hist3[0], acc3} == {1'b0, $past(acc3)} + {1'b0, $past(acc2)}));

  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (held == '0 && acc1 == '0 && acc2 == '0 && acc3 == '0 &&
     hist1 == '0 && hist2 == '0 && hist3 == '0) |=> level_out == '0);

endmodule

// File: tb/mash3_modulator_tb.sv
module mash3_modulator_tb_top;

  localparam int CODE_W = 16;
  localparam longint MOD = longint'(1) << CODE_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              code_valid = 1'b0;
  logic [CODE_W-1:0] code_in = '0;
  logic [3:0]        level_out;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  longint m_held, m_a1, m_a2, m_a3;
  int q1[$], q2[$], q3[$];
  int exp_level;
  longint run_sum;

  always #10 clk = ~clk;

  mash3_modulator #(.CODE_W(CODE_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .code_valid(code_valid),
    .code_in(code_in), .level_out(level_out)
  );

  function automatic int as_signed(input logic [3:0] v);
    return (v[3]) ? int'(v) - 16 : int'(v);
  endfunction

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic model_reset();
    m_held = 0; m_a1 = 0; m_a2 = 0; m_a3 = 0;
    q1 = '{0, 0}; q2 = '{0, 0}; q3 = '{0, 0};
    exp_level = 0;
  endtask

  task automatic model_edge(input bit v, input longint d);
    int b1, b2, b3;
    longint n1, n2, n3;
    b1 = (m_a1 + m_held >= MOD) ? 1 : 0;
    b2 = (m_a2 + m_a1 >= MOD) ? 1 : 0;
    b3 = (m_a3 + m_a2 >= MOD) ? 1 : 0;
    exp_level = q1[1] + q2[0] - q2[1] + b3 - 2 * q3[0] + q3[1];
    n1 = (m_a1 + m_held) % MOD;
    n2 = (m_a2 + m_a1) % MOD;
    n3 = (m_a3 + m_a2) % MOD;
    m_a1 = n1; m_a2 = n2; m_a3 = n3;
    if (v) m_held = d;
    q1.push_front(b1); void'(q1.pop_back());
    q2.push_front(b2); void'(q2.pop_back());
    q3.push_front(b3); void'(q3.pop_back());
  endtask

  task automatic step(input bit v, input longint d, input string req);
    code_valid = v;
    code_in = CODE_W'(d);
    @(posedge clk);
    model_edge(v, d);
    @(negedge clk);
    check(req, as_signed(level_out), exp_level);
    check("R3", (as_signed(level_out) >= -3 && as_signed(level_out) <= 4) ? 1 : 0, 1);
    run_sum += as_signed(level_out);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    code_valid = 1'b0;
    code_in = '0;
    model_reset();
    repeat (3) @(negedge clk);
    check("R1", as_signed(level_out), 0);
    rst_n = 1'b1;
    run_sum = 0;
  endtask

  task automatic mean_run(input longint x, input int len);
    longint expv, diff;
    do_reset();
    for (int i = 0; i < len; i++) step(1'b1, x, "R4");
    expv = ((longint'(len) - 3) * x) / MOD;
    diff = run_sum - expv;
    if (diff < 0) diff = -diff;
    check("R6", (diff <= 2) ? 1 : 0, 1);
  endtask

  initial begin
    do_reset();
    for (int i = 0; i < 20; i++) step(1'b1, 0, "R1");

    do_reset();
    step(1'b1, MOD - 1, "R7");
    step(1'b0, 0, "R8");
    check("R8", as_signed(level_out), 0);
    step(1'b0, 0, "R8");
    check("R8", as_signed(level_out), 0);
    for (int i = 0; i < 200; i++) step(1'b0, longint'($urandom) % MOD, "R2");

    do_reset();
    for (int i = 0; i < 300; i++) step(1'b1, (i % 2 == 0) ? MOD - 1 : 0, "R7");

    do_reset();
    for (int i = 0; i < 3000; i++) step(1'b1, longint'($urandom) % MOD, "R5");

    do_reset();
    for (int i = 0; i < 3000; i++)
      step(($urandom % 4) == 0, longint'($urandom) % MOD, "R2");

    mean_run(MOD / 4, 4096);
    mean_run(MOD - 1, 4096);
    mean_run(1237, 8192);
    mean_run(1, 2048);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule